// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a one-stage execution unit for 64-bit packed integer operations. It sits behind a multimedia register file. Each issue cycle it receives four things: the destination register value, two candidate source operands (a second register and a 64-bit memory operand), the second opcode byte that follows the two-byte escape, and the two-bit addressing-mode field. The mode field picks the source operand. The opcode byte is decoded inside the block into one of nine operations, and the 64-bit result is returned for write-back to the destination register.

The operations are:
- wrap-around addition on four 16-bit lanes;
- full-width AND;
- AND-NOT, in which the destination operand is the one complemented;
- element-wise equality compares and signed greater-than compares at byte, word and dword size. Each compare writes an all-ones or all-zeros mask into every element.

An opcode byte outside the supported set raises an illegal-operation strobe in place of a result.

Every operation takes one clock, and a new one can be issued on every clock.

Top module: `simd_lane_alu`

## Requirements
- R1: When `in_valid` is high at a rising edge and the opcode is legal, `out_valid` is high for exactly the following cycle and carries that operation's result; `out_valid` is low after any edge at which `in_valid` was low.
- R2: The source operand is `reg_src` when `modrm_mod` equals 2'b11, and `mem_src` for every other mode value.
- R3: Opcode 8'hFD adds dst and source as four independent 16-bit lanes; each lane sum is taken modulo 2^16 and no carry enters the next lane.
- R4: Opcode 8'hDB returns dst AND source over all 64 bits.
- R5: Opcode 8'hDF returns (NOT dst) AND source over all 64 bits.
- R6: Opcodes 8'h74, 8'h75 and 8'h76 compare 8-, 16- and 32-bit elements for equality; each result element is all ones when dst equals source in that element, and all zeros otherwise.
- R7: Opcodes 8'h64, 8'h65 and 8'h66 compare 8-, 16- and 32-bit elements as two's-complement signed values; each result element is all ones when the dst element is strictly greater than the source element, and all zeros otherwise.
- R8: Any other opcode byte raises `out_illegal` for the next cycle, keeps `out_valid` low, and leaves `out_result` unchanged; `out_valid` and `out_illegal` are never high together.
- R9: A synchronous reset drives `out_valid` and `out_illegal` low and `out_result` to zero.
- R10: Operations issued on consecutive cycles each produce their own result on consecutive cycles.
- R11: `out_result` keeps its value on every cycle that follows an edge with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for the current operands and opcode |
| opc_byte | input | 8 | Opcode byte following the escape byte |
| modrm_mod | input | 2 | Addressing-mode field; 2'b11 selects the register source |
| dst_val | input | 64 | Destination register operand |
| reg_src | input | 64 | Second register operand |
| mem_src | input | 64 | Memory operand |
| out_valid | output | 1 | Result strobe, one cycle after a legal issue |
| out_illegal | output | 1 | Strobe, one cycle after an issue with an unknown opcode |
| out_result | output | 64 | Result for write-back to the destination |

## Verification
Every outcome, whether a result, an illegal strobe or a held value, is due exactly one rising edge after the issue cycle. The block has a single register stage on the path from the inputs to the outputs. The driver stamps each expected item with the edge count at which it becomes due. The monitor samples on the falling edge and pops an item only when the current edge count matches that stamp. An item pushed at the same falling edge is therefore never compared too early. Idle and illegal cycles push their own items, so held results and the exclusive strobes are checked every cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADDW,
        OP_AND,
        OP_ANDN,
        OP_EQB,
        OP_EQW,
        OP_EQD,
        OP_GTB,
        OP_GTW,
        OP_GTD
    } simd_op_e;

    localparam logic [7:0] OPC_ADDW = 8'hFD;
    localparam logic [7:0] OPC_AND  = 8'hDB;
    localparam logic [7:0] OPC_ANDN = 8'hDF;
    localparam logic [7:0] OPC_EQB  = 8'h74;
    localparam logic [7:0] OPC_EQW  = 8'h75;
    localparam logic [7:0] OPC_EQD  = 8'h76;
    localparam logic [7:0] OPC_GTB  = 8'h64;
    localparam logic [7:0] OPC_GTW  = 8'h65;
    localparam logic [7:0] OPC_GTD  = 8'h66;

    localparam logic [1:0] MODE_REG = 2'b11;

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_alu_pkg::*;
(
    input  logic [7:0] opc_byte,
    output simd_op_e   op,
    output logic       legal
);
    always_comb begin
        op    = OP_AND;
        legal = 1'b1;
        case (opc_byte)
            OPC_ADDW: op = OP_ADDW;
            OPC_AND:  op = OP_AND;
            OPC_ANDN: op = OP_ANDN;
            OPC_EQB:  op = OP_EQB;
            OPC_EQW:  op = OP_EQW;
            OPC_EQD:  op = OP_EQD;
            OPC_GTB:  op = OP_GTB;
            OPC_GTW:  op = OP_GTW;
            OPC_GTD:  op = OP_GTD;
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_wrap_add.sv
module simd_wrap_add #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sum[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes #(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] eq_mask,
    output logic [DATA_W-1:0] gt_mask
);
    localparam int ELEMS = DATA_W / ELEM_W;

    for (genvar i = 0; i < ELEMS; i++) begin : g_elem
        logic signed [ELEM_W-1:0] ea;
        logic signed [ELEM_W-1:0] eb;
        assign ea = a[i*ELEM_W +: ELEM_W];
        assign eb = b[i*ELEM_W +: ELEM_W];
        assign eq_mask[i*ELEM_W +: ELEM_W] = {ELEM_W{ea == eb}};
        assign gt_mask[i*ELEM_W +: ELEM_W] = {ELEM_W{ea > eb}};
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        opc_byte,
    input  logic [1:0]        modrm_mod,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] reg_src,
    input  logic [DATA_W-1:0] mem_src,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [DATA_W-1:0] out_result
);
    localparam int N_SIZES = 3;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t   state_d, state_q;
    simd_op_e op_sel;
    logic     op_legal;

    logic [DATA_W-1:0] src_opnd;
    logic [DATA_W-1:0] add_res;
    logic [DATA_W-1:0] eq_res [N_SIZES];
    logic [DATA_W-1:0] gt_res [N_SIZES];
    logic [DATA_W-1:0] alu_res;

    assign src_opnd = (modrm_mod == MODE_REG) ? reg_src : mem_src;

    simd_op_decode dec_i (
        .opc_byte (opc_byte),
        .op       (op_sel),
        .legal    (op_legal)
    );

    simd_wrap_add #(.DATA_W(DATA_W), .LANE_W(ADD_W)) add_i (
        .a   (dst_val),
        .b   (src_opnd),
        .sum (add_res)
    );

    // element sizes 8, 16, 32
    for (genvar s = 0; s < N_SIZES; s++) begin : g_cmp
        simd_cmp_lanes #(.DATA_W(DATA_W), .ELEM_W(8 << s)) cmp_i (
            .a       (dst_val),
            .b       (src_opnd),
            .eq_mask (eq_res[s]),
            .gt_mask (gt_res[s])
        );
    end

    always_comb begin
        case (op_sel)
            OP_ADDW: alu_res = add_res;
            OP_AND:  alu_res = dst_val & src_opnd;
            OP_ANDN: alu_res = ~dst_val & src_opnd;
            OP_EQB:  alu_res = eq_res[0];
            OP_EQW:  alu_res = eq_res[1];
            OP_EQD:  alu_res = eq_res[2];
            OP_GTB:  alu_res = gt_res[0];
            OP_GTW:  alu_res = gt_res[1];
            OP_GTD:  alu_res = gt_res[2];
            default: alu_res = '0;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        state_d.ill = 1'b0;
        if (in_valid) begin
            if (op_legal) begin
                state_d.vld = 1'b1;
                state_d.res = alu_res;
            end else begin
                state_d.ill = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.vld;
    assign out_illegal = state_q.ill;
    assign out_result  = state_q.res;
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        opc_byte,
    input logic [1:0]        modrm_mod,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] reg_src,
    input logic [DATA_W-1:0] mem_src,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [DATA_W-1:0] out_result
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    // R1
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8
    illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> $past(in_valid));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(out_result));

    // R5
    andn_reg_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && opc_byte == 8'hDF && modrm_mod == 2'b11) && !$past(rst))
        |-> out_result == (~$past(dst_val) & $past(reg_src)));

    // R2
    and_mem_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && opc_byte == 8'hDB && modrm_mod != 2'b11) && !$past(rst))
        |-> out_result == ($past(dst_val) & $past(mem_src)));

    // R3
    add_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && opc_byte == 8'hFD && modrm_mod == 2'b11) && !$past(rst))
        |-> out_result[15:0] == $past(dst_val[15:0] + reg_src[15:0]));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .opc_byte    (opc_byte),
    .modrm_mod   (modrm_mod),
    .dst_val     (dst_val),
    .reg_src     (reg_src),
    .mem_src     (mem_src),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb_top;

    typedef struct {
        int          due;
        logic        vld;
        logic        ill;
        logic [63:0] res;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  opc_byte = 8'h00;
    logic [1:0]  modrm_mod = 2'b11;
    logic [63:0] dst_val = '0;
    logic [63:0] reg_src = '0;
    logic [63:0] mem_src = '0;
    logic        out_valid;
    logic        out_illegal;
    logic [63:0] out_result;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    exp_t sb_q[$];
    logic [63:0] last_res = '0;
    bit   finished = 0;

    simd_lane_alu dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .opc_byte    (opc_byte),
        .modrm_mod   (modrm_mod),
        .dst_val     (dst_val),
        .reg_src     (reg_src),
        .mem_src     (mem_src),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_result  (out_result)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] eq_ref(logic [63:0] a, logic [63:0] b, int w);
        logic [63:0] r = '0;
        logic [63:0] m = (64'd1 << w) - 64'd1;
        for (int e = 0; e < 64 / w; e++) begin
            if (((a >> (e * w)) & m) == ((b >> (e * w)) & m)) r |= m << (e * w);
        end
        return r;
    endfunction

    function automatic logic [63:0] gt_ref(logic [63:0] a, logic [63:0] b, int w);
        logic [63:0] r = '0;
        logic [63:0] m = (64'd1 << w) - 64'd1;
        logic [63:0] sb = 64'd1 << (w - 1);
        for (int e = 0; e < 64 / w; e++) begin
            // flipping the sign bit turns a signed order into an unsigned one
            if ((((a >> (e * w)) & m) ^ sb) > (((b >> (e * w)) & m) ^ sb)) r |= m << (e * w);
        end
        return r;
    endfunction

    function automatic bit legal_ref(logic [7:0] op);
        return op inside {8'hFD, 8'hDB, 8'hDF, 8'h74, 8'h75, 8'h76, 8'h64, 8'h65, 8'h66};
    endfunction

    function automatic logic [63:0] alu_ref(logic [7:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        case (op)
            8'hFD: for (int l = 0; l < 4; l++) r[l*16 +: 16] = a[l*16 +: 16] + b[l*16 +: 16];
            8'hDB: r = a & b;
            8'hDF: r = ~a & b;
            8'h74: r = eq_ref(a, b, 8);
            8'h75: r = eq_ref(a, b, 16);
            8'h76: r = eq_ref(a, b, 32);
            8'h64: r = gt_ref(a, b, 8);
            8'h65: r = gt_ref(a, b, 16);
            8'h66: r = gt_ref(a, b, 32);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic issue(string tag, logic [7:0] op, logic [1:0] md,
                         logic [63:0] d, logic [63:0] rs, logic [63:0] ms);
        exp_t it;
        logic [63:0] s;
        @(negedge clk);
        in_valid  = 1'b1;
        opc_byte  = op;
        modrm_mod = md;
        dst_val   = d;
        reg_src   = rs;
        mem_src   = ms;
        s = (md == 2'b11) ? rs : ms;
        it.due = cyc + 1;
        it.tag = tag;
        if (legal_ref(op)) begin
            last_res = alu_ref(op, d, s);
            it.vld = 1'b1;
            it.ill = 1'b0;
        end else begin
            it.vld = 1'b0;
            it.ill = 1'b1;
        end
        it.res = last_res;
        sb_q.push_back(it);
    endtask

    task automatic idle(string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b0;
        dst_val  = 64'hDEAD_BEEF_0BAD_F00D;
        reg_src  = ~dst_val;
        opc_byte = 8'hDB;
        it.due = cyc + 1;
        it.tag = tag;
        it.vld = 1'b0;
        it.ill = 1'b0;
        it.res = last_res;
        sb_q.push_back(it);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            check({it.tag, " valid"},   {63'd0, out_valid},   {63'd0, it.vld});
            check({it.tag, " illegal"}, {63'd0, out_illegal}, {63'd0, it.ill});
            check({it.tag, " result"},  out_result, it.res);
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 valid after reset",   {63'd0, out_valid},   64'd0);
        check("R9 illegal after reset", {63'd0, out_illegal}, 64'd0);
        check("R9 result after reset",  out_result, 64'd0);

        // R3 lane wrap and no carry across lanes
        issue("R3 wrap", 8'hFD, 2'b11, 64'hFFFF_8000_0001_FFFF, 64'h0001_8000_FFFF_0001, '0);
        issue("R3 boundary", 8'hFD, 2'b11, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, '0);
        // R4 and R2 mem form
        issue("R4 and reg", 8'hDB, 2'b11, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_5555_FFFF, 64'h0);
        issue("R2 and mem", 8'hDB, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0123_4567_89AB_CDEF);
        // R5
        issue("R5 andn reg", 8'hDF, 2'b11, 64'hFF00_FF00_AAAA_0000, 64'hFFFF_0F0F_FFFF_1234, '0);
        issue("R5 andn mem", 8'hDF, 2'b01, 64'h0F0F_0F0F_0F0F_0F0F, '1, 64'hFFFF_0000_FFFF_0000);
        idle("R11 idle after burst");
        // R6 equality at each size
        issue("R6 eq byte", 8'h74, 2'b11, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, '0);
        issue("R6 eq word", 8'h75, 2'b10, 64'h1122_3344_5566_7788, '0, 64'h1122_0000_5566_7789);
        issue("R6 eq dword", 8'h76, 2'b11, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_CCCC_DDDE, '0);
        // R7 signed greater-than at each size
        issue("R7 gt byte", 8'h64, 2'b11, 64'h7F80_0001_FF00_0505, 64'h807F_01FF_00FF_0504, '0);
        issue("R7 gt word", 8'h65, 2'b11, 64'h7FFF_8000_0000_FFFF, 64'h8000_7FFF_FFFF_FFFF, '0);
        issue("R7 gt dword", 8'h66, 2'b00, 64'h0000_0001_8000_0000, '0, 64'hFFFF_FFFF_7FFF_FFFF);
        // R8 illegal opcodes keep the previous result
        issue("R8 illegal 00", 8'h00, 2'b11, '1, '1, '1);
        issue("R8 illegal FC", 8'hFC, 2'b11, '1, '1, '1);
        idle("R11 idle");
        idle("R11 idle again");

        // R10 random back-to-back traffic
        for (int k = 0; k < 400; k++) begin
            logic [7:0] ops[10] = '{8'hFD, 8'hDB, 8'hDF, 8'h74, 8'h75, 8'h76, 8'h64, 8'h65, 8'h66, 8'h67};
            logic [63:0] d, rs, ms;
            d  = {$urandom, $urandom};
            rs = ($urandom_range(0, 3) == 0) ? d ^ (64'hFF << (8 * $urandom_range(0, 7))) : {$urandom, $urandom};
            ms = ($urandom_range(0, 3) == 0) ? d : {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) idle("R11 random idle");
            else issue("R10 random", ops[$urandom_range(0, 9)], 2'($urandom_range(0, 3)), d, rs, ms);
        end
        idle("R1 drain");
        repeat (3) @(negedge clk);

        // R9 reset mid-stream
        issue("R1 before reset", 8'hDB, 2'b11, '1, 64'h55, '0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 valid cleared",  {63'd0, out_valid},   64'd0);
        check("R9 result cleared", out_result, 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule